// File: doc/BRIEF.md
# Deadline-Aware Back-Jump Controller

This block decides when a logic-locked circuit falls back into its locked state, and which locked state it lands in. Two events open the circuit: a successful authentication, or a time-critical task trigger that arrives while the circuit is locked. On an authentication, the hold time of the open window is taken from a pseudo-random sample. On a task trigger, the hold time is the deadline figure that comes with the trigger, so the task runs to completion without a key. An internal cycle counter starts from zero on every entry into the open mode.

While the circuit is open, the stored hold time is raised on every cycle to at least the present deadline plus the counter value. A critical task that is running, or that is queued, therefore always finishes before the lock returns. The circuit relocks on the first cycle where the counter has reached the stored hold time and the deadline input is zero. On that cycle the controller emits a one-cycle request and a landing-state index. The index mixes the pseudo-random sample with the current primary input word.

The deadline value and the random sample come from outside the block. Task scheduling and the random generator are not part of it.

Top module: `deadline_bj_ctrl`

## Requirements
- R1: After reset, and after any reset applied in the open mode, the circuit is locked, `bj_req` is 0 and `bj_state` is 0. No request appears until the circuit is opened again.
- R2: When `auth_ok` is 1 in the locked mode at clock edge E, the hold time P is the value of `rnd` at E. If the deadline stays 0, `bj_req` goes high right after edge E+P+1.
- R3: When `task_hit` is 1 and `auth_ok` is 0 in the locked mode at edge E, the hold time is the value of `deadline` at E, not `rnd`.
- R4: In the open mode, at every edge the hold time becomes max(hold, deadline + counter), where the counter is 0 at the first edge after entry. A relock happens only at an edge where the counter equals the updated hold time. A nonzero deadline at that edge therefore postpones the relock.
- R5: The sum deadline + counter saturates at 2^CW-1 instead of wrapping.
- R6: At the relock edge, `bj_state` is loaded with `rnd[SW-1:0] XOR pin[SW-1:0]`. At every other edge it holds its value.
- R7: `bj_req` is a single-cycle pulse. After a relock the circuit is locked: `deadline`, `rnd` and `pin` cause no request and no change of `bj_state` until the next entry. The counter is restarted from zero on that entry.
- R8: When `auth_ok` and `task_hit` are both 1 at the entry edge, authentication wins and the hold time comes from `rnd`.
- R9: In the open mode, `auth_ok` and `task_hit` have no effect. Neither the hold time nor the relock cycle changes because of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auth_ok | input | 1 | Key sequence accepted in this cycle |
| task_hit | input | 1 | A time-critical task is triggered in this cycle |
| deadline | input | CW | Remaining uninterrupted cycles for the running and queued critical tasks, 0 when idle |
| rnd | input | CW | Pseudo-random sample |
| pin | input | IW | Current primary input word |
| bj_req | output | 1 | One-cycle relock request |
| bj_state | output | SW | Index of the locked state to land in |

## Verification
A wrong hold time or a counter that is not cleared shows up only as a `bj_req` pulse at the wrong edge. A window that is too short can go unseen for up to 2^CW cycles. For that reason every scenario counts edges from entry up to the pulse and compares the count exactly. The checks cover both entry causes, stretches that do and do not lengthen the window, a deadline that is present on the edge where the counter reaches the hold time, and the saturation case of a full-scale window. A `bj_state` that has been loaded wrongly stays visible until the next relock, so it is checked on the cycle of every pulse and watched for drift during locked stretches.

// File: rtl/deadline_bj_pkg.sv
package deadline_bj_pkg;

    typedef enum logic {
        MODE_LOCKED = 1'b0,
        MODE_OPEN   = 1'b1
    } mode_e;

    // Entry decision taken in the locked mode
    typedef struct packed {
        logic go;       // leave the locked mode this cycle
        logic by_key;   // authentication wins over a task trigger
    } entry_t;

    function automatic entry_t decide_entry(input logic key_ok, input logic crit);
        entry_t e;
        e.go     = key_ok | crit;
        e.by_key = key_ok;
        return e;
    endfunction

endpackage

// File: rtl/bjc_counter.sv
module bjc_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bjc_period.sv
module bjc_period #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          track,
    input  logic [CW-1:0] deadline,
    input  logic [CW-1:0] cnt,
    output logic [CW-1:0] per_q,
    output logic [CW-1:0] per_next
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    logic [CW:0]   wide_sum;
    logic [CW-1:0] need;

    always_comb begin
        wide_sum = {1'b0, deadline} + {1'b0, cnt};
        need     = wide_sum[CW] ? TOP : wide_sum[CW-1:0];
        per_next = (need > per_q) ? need : per_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= '0;
        end else if (load) begin
            per_q <= load_val;
        end else if (track) begin
            per_q <= per_next;
        end
    end
endmodule

// File: rtl/bjc_index.sv
module bjc_index #(
    parameter int CW = 8,
    parameter int IW = 8,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [CW-1:0] rnd,
    input  logic [IW-1:0] pin,
    output logic [SW-1:0] idx
);
    logic [SW-1:0] mix;

    for (genvar b = 0; b < SW; b++) begin : g_mix
        assign mix[b] = rnd[b] ^ pin[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (capture) begin
            idx <= mix;
        end
    end
endmodule

// File: rtl/deadline_bj_ctrl.sv
module deadline_bj_ctrl
    import deadline_bj_pkg::*;
#(
    parameter int CW = 8,
    parameter int IW = 8,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          auth_ok,
    input  logic          task_hit,
    input  logic [CW-1:0] deadline,
    input  logic [CW-1:0] rnd,
    input  logic [IW-1:0] pin,
    output logic          bj_req,
    output logic [SW-1:0] bj_state
);
    mode_e         mode_q;
    logic          open_q;
    entry_t        ent;
    logic          enter;
    logic          jump;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] per_q;
    logic [CW-1:0] per_next;
    logic [CW-1:0] load_val;

    assign open_q   = (mode_q == MODE_OPEN);
    assign ent      = decide_entry(auth_ok, task_hit);
    assign enter    = !open_q && ent.go;
    assign jump     = open_q && (cnt_q == per_next);
    assign load_val = ent.by_key ? rnd : deadline;

    bjc_counter #(.CW(CW)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (enter),
        .inc (open_q && !jump),
        .cnt (cnt_q)
    );

    bjc_period #(.CW(CW)) u_per (
        .clk      (clk),
        .rst      (rst),
        .load     (enter),
        .load_val (load_val),
        .track    (open_q && !jump),
        .deadline (deadline),
        .cnt      (cnt_q),
        .per_q    (per_q),
        .per_next (per_next)
    );

    bjc_index #(.CW(CW), .IW(IW), .SW(SW)) u_idx (
        .clk     (clk),
        .rst     (rst),
        .capture (jump),
        .rnd     (rnd),
        .pin     (pin),
        .idx     (bj_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_LOCKED;
            bj_req <= 1'b0;
        end else begin
            bj_req <= jump;
            if (enter) begin
                mode_q <= MODE_OPEN;
            end else if (jump) begin
                mode_q <= MODE_LOCKED;
            end
        end
    end
endmodule

// File: rtl/deadline_bj_ctrl_chk.sv
module deadline_bj_ctrl_chk #(
    parameter int CW = 8,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          bj_req,
    input logic [SW-1:0] bj_state,
    input logic          open_q,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] per
);
    // R7
    req_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bj_req |=> !bj_req);

    // R6
    state_only_on_req_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(bj_state) |-> bj_req);

    // R2
    req_leaves_open_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bj_req) |-> (!open_q && $past(open_q)));

    // R4
    cnt_within_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= per);

    // R4
    hold_never_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
        (open_q && $past(open_q)) |-> (per >= $past(per)));
endmodule

bind deadline_bj_ctrl deadline_bj_ctrl_chk #(.CW(CW), .SW(SW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bj_req   (bj_req),
    .bj_state (bj_state),
    .open_q   (open_q),
    .cnt      (cnt_q),
    .per      (per_q)
);

// File: tb/deadline_bj_ctrl_test.sv
module deadline_bj_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    typedef struct packed {
        logic        a;
        logic        t;
        logic [7:0]  pent;
        logic [7:0]  dent;
        logic [15:0] sk;
        logic [7:0]  sv;
        logic [7:0]  q;
        logic [7:0]  w;
        logic [15:0] en;
    } vec_t;

    // fields: auth, task, rnd at entry, deadline at entry, stretch edge,
    // stretch deadline, rnd during wait, pin during wait, expected edges
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'd5,   8'd0, 16'd0, 8'd0,   8'h3C, 8'hA5, 16'd6},   // R2
        '{1'b1, 1'b0, 8'd0,   8'd0, 16'd0, 8'd0,   8'h0F, 8'h01, 16'd1},   // R2 zero hold
        '{1'b0, 1'b1, 8'h77,  8'd6, 16'd0, 8'd0,   8'h12, 8'h34, 16'd7},   // R3
        '{1'b0, 1'b1, 8'h10,  8'd2, 16'd3, 8'd3,   8'h9A, 8'h0B, 16'd6},   // R3 queued task
        '{1'b1, 1'b1, 8'd2,   8'd9, 16'd0, 8'd0,   8'hFF, 8'h00, 16'd3},   // R8
        '{1'b1, 1'b0, 8'd5,   8'd0, 16'd4, 8'd4,   8'h55, 8'hAA, 16'd8},   // R4 stretch
        '{1'b1, 1'b0, 8'd9,   8'd0, 16'd3, 8'd4,   8'hC3, 8'h5E, 16'd10},  // R4 no stretch
        '{1'b1, 1'b0, 8'd2,   8'd0, 16'd3, 8'd1,   8'h81, 8'h7F, 16'd4},   // R4 deadline at reach
        '{1'b1, 1'b0, 8'd3,   8'd0, 16'd3, 8'hFF,  8'h6D, 8'h92, 16'd256}  // R5 saturate
    };

    function automatic string vtag(input int i);
        case (i)
            0, 1:       return "R2";
            2, 3:       return "R3";
            4:          return "R8";
            5, 6, 7:    return "R4";
            default:    return "R5";
        endcase
    endfunction

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       auth_ok = 1'b0;
    logic       task_hit = 1'b0;
    logic [7:0] deadline = '0;
    logic [7:0] rnd = '0;
    logic [7:0] pin = '0;
    logic       bj_req;
    logic [3:0] bj_state;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    deadline_bj_ctrl #(.CW(8), .IW(8), .SW(4)) uut (
        .clk      (clk),
        .rst      (rst),
        .auth_ok  (auth_ok),
        .task_hit (task_hit),
        .deadline (deadline),
        .rnd      (rnd),
        .pin      (pin),
        .bj_req   (bj_req),
        .bj_state (bj_state)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive entry at edge E, then count edges until bj_req is seen
    task automatic run_case(input vec_t v, input string req);
        int seen = 0;
        @(negedge clk);
        auth_ok = v.a; task_hit = v.t; rnd = v.pent; deadline = v.dent;
        @(posedge clk);
        @(negedge clk);
        auth_ok = 0; task_hit = 0;
        for (int n = 1; n <= 300; n++) begin
            deadline = (n == int'(v.sk)) ? v.sv : 8'd0;
            rnd = v.q; pin = v.w;
            @(posedge clk);
            @(negedge clk);
            if (bj_req) begin seen = n; break; end
        end
        deadline = 0;
        check(seen == int'(v.en), req, seen, int'(v.en));
        check(bj_state == ((v.q ^ v.w) & 8'h0F), "R6", bj_state, (v.q ^ v.w) & 8'h0F);
        @(posedge clk);
        @(negedge clk);
        check(bj_req == 1'b0, "R7", bj_req, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] held;
        bit quiet;
        int seen;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        check(bj_req == 0, "R1", bj_req, 0);
        check(bj_state == 0, "R1", bj_state, 0);

        for (int i = 0; i < NV; i++) begin
            run_case(VECS[i], vtag(i));
        end

        // R7: locked mode ignores deadline, rnd and pin
        held = bj_state;
        quiet = 1;
        for (int k = 0; k < 20; k++) begin
            deadline = 8'(k * 13 + 1); rnd = 8'(k * 29); pin = 8'(k * 7 + 3);
            @(posedge clk);
            @(negedge clk);
            if (bj_req || bj_state != held) quiet = 0;
        end
        deadline = 0;
        check(quiet, "R7", quiet, 1);

        // R9: auth_ok / task_hit in the open mode change nothing
        auth_ok = 1; rnd = 8'd4;
        @(posedge clk);
        @(negedge clk);
        auth_ok = 0;
        seen = 0;
        for (int n = 1; n <= 100; n++) begin
            auth_ok = (n == 2); task_hit = (n == 2);
            rnd = (n == 2) ? 8'd60 : 8'd4;
            deadline = (n == 2) ? 8'd0 : 8'd0;
            @(posedge clk);
            @(negedge clk);
            if (bj_req) begin seen = n; break; end
        end
        auth_ok = 0; task_hit = 0;
        check(seen == 5, "R9", seen, 5);

        // R1: reset while open kills the pending relock
        @(negedge clk);
        auth_ok = 1; rnd = 8'd3;
        @(posedge clk);
        @(negedge clk);
        auth_ok = 0; rst = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        quiet = 1;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (bj_req || bj_state != 0) quiet = 0;
        end
        check(quiet, "R1", quiet, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule